// File: doc/BRIEF.md
# Frame Base Address Latch with Update Interrupt

This block holds the start address of the frame buffer that a pixel fetch engine reads from. Software may write a new base address over a small register bus at any time. The value is held as pending and only becomes the active address, seen by the fetch side, on the next frame-start pulse from the display timing generator. On the frame start that performs the load, a raw "base updated" status bit is set. Software can use that bit to learn that the old buffer is no longer being scanned, so it can be reused.

The status bit is gated by an enable register to form a masked status and a level interrupt output. Software acknowledges the interrupt by writing ones to a clear register. A frame start that finds no pending address changes nothing and raises nothing. Base addresses are word aligned, so the two low bits of every written address are dropped.

The register map uses word addresses on a 3-bit bus:

| Address | Register | Access |
|---|---|---|
| 0 | pending base | read/write |
| 1 | active base | read-only |
| 2 | interrupt enable | read/write |
| 3 | raw status | read-only |
| 4 | masked status | read-only |
| 5 | interrupt clear | write-only |

Addresses 5 to 7 read as zero. The base-updated event is status bit 0.

Top module: `frame_base_irq`

## Requirements
- R1: After reset the pending base, active base, enable and raw status all read zero, and irq is low.
- R2: A bus write to address 0 stores the written data with bits [1:0] forced to zero as the pending base. The active base (address 1 and the activeBase port) does not change on that write.
- R3: A frameStart pulse while an address is pending copies the pending base into the active base and sets raw status bit 0. Both changes are visible in the cycle after the pulse.
- R4: A frameStart pulse with no address pending leaves the active base and the raw status unchanged.
- R5: When several base writes fall before one frame start, only the last written value is loaded. Only one load event takes place, and a later frame start with no new write sets nothing.
- R6: A base write in the same cycle as frameStart does not take part in that frame start. The previously pending value, if any, is loaded, and the new value stays pending for the next frame start.
- R7: The masked status (address 4) reads as raw status AND enable, and irq is high exactly when the masked status is non-zero. Writing 0 to the enable register (address 2) masks the interrupt, and writing bit 0 as one enables it.
- R8: A write to address 5 clears every raw status bit that is one in the written data and leaves the other bits unchanged. Writing 0 clears nothing.
- R9: When a clear write and a load event fall in the same cycle, raw status bit 0 ends up set.
- R10: Raw status bit 0, and with it irq when enabled, stays set over any number of idle cycles and frame starts until it is cleared.
- R11: Only bit 0 of the enable and raw status registers is stored, and all other bits read zero. Bus writes to addresses 1, 3 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle pulse at the start of each frame |
| busWrite | input | 1 | Register write strobe |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| activeBase | output | 32 | Base address used by the fetch side |
| irq | output | 1 | Level interrupt, OR of masked status bits |

## Verification
Two pairs of events can meet in one cycle: a base write with the frame-start pulse, and a status clear with the load event that sets the status. The bench provokes both by asserting busWrite and frameStart on the same clock edge. For the first pair, it reads back both the active and the pending base, expecting the old pending value to be active and the new one to be held. For the second pair, it reads the raw status, expecting it to be set. A behavioural model updated on every clock checks the read data, activeBase and irq in each cycle in addition to these directed reads.

// File: rtl/fbi_pkg.sv
package fbi_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int ALIGN_BITS = 2;
  localparam int UPD_BIT = 0;

  localparam logic [ADDR_W-1:0] A_PEND   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ACTIVE = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd2;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASKED = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd5;

  typedef struct packed {
    logic wrBase;
    logic wrEnable;
    logic doClear;
    logic loadBase;
  } ctlStrobes_t;
endpackage

// File: rtl/fbi_ctrl.sv
module fbi_ctrl
  import fbi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobes_t       st
);
  logic pendingFlag;

  always_comb begin
    st.wrBase   = busWrite && (busAddr == A_PEND);
    st.wrEnable = busWrite && (busAddr == A_ENABLE);
    st.doClear  = busWrite && (busAddr == A_CLEAR);
    st.loadBase = frameStart && pendingFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendingFlag <= 1'b0;
    else       pendingFlag <= st.wrBase || (pendingFlag && !frameStart);
  end

  // R4: nothing is loaded when no address is pending
  assert_no_load_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !pendingFlag) |-> !st.loadBase);

  // R3: a load happens only on a frame start
  assert_load_on_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    st.loadBase |-> frameStart);
endmodule

// File: rtl/fbi_datapath.sv
module fbi_datapath
  import fbi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       st,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] activeBase,
  output logic              irq
);
  logic [DATA_W-1:0] pendingBase;
  logic              enUpd;
  logic              rawUpd;
  logic              rawNext;

  always_comb begin
    rawNext = rawUpd;
    if (st.doClear && busWdata[UPD_BIT]) rawNext = 1'b0;
    if (st.loadBase)                     rawNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingBase <= '0;
      activeBase  <= '0;
      enUpd       <= 1'b0;
      rawUpd      <= 1'b0;
    end else begin
      if (st.wrBase)
        pendingBase <= {busWdata[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      if (st.loadBase)
        activeBase <= pendingBase;
      if (st.wrEnable)
        enUpd <= busWdata[UPD_BIT];
      rawUpd <= rawNext;
    end
  end

  assign irq = rawUpd && enUpd;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_PEND:   busRdata = pendingBase;
      A_ACTIVE: busRdata = activeBase;
      A_ENABLE: busRdata[UPD_BIT] = enUpd;
      A_RAW:    busRdata[UPD_BIT] = rawUpd;
      A_MASKED: busRdata[UPD_BIT] = rawUpd && enUpd;
      default:  busRdata = '0;
    endcase
  end

  // R2: the active base moves only on a load
  assert_active_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !st.loadBase |=> $stable(activeBase));

  // R3 and R9: a load leaves the status set, even with a clear in the same cycle
  assert_load_sets_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    st.loadBase |=> rawUpd);

  // R10: the status holds until a clear write carrying bit 0
  assert_status_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rawUpd && !(st.doClear && busWdata[UPD_BIT])) |=> rawUpd);

  // R7: a disabled source never drives the interrupt
  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enUpd |-> !irq);
endmodule

// File: rtl/frame_base_irq.sv
module frame_base_irq
  import fbi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] activeBase,
  output logic              irq
);
  ctlStrobes_t st;

  fbi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .busWrite(busWrite), .busAddr(busAddr), .st(st)
  );

  fbi_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .activeBase(activeBase), .irq(irq)
  );
endmodule

// File: tb/frame_base_irq_bench.sv
module frame_base_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] activeBase;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model
  logic [31:0] mPend, mAct;
  bit mFlag, mEn, mRaw;

  frame_base_irq u_frame_base_irq (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .activeBase(activeBase), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = 0; mAct = 0; mFlag = 0; mEn = 0; mRaw = 0;
    end else begin
      bit load;
      load = frameStart && mFlag;
      if (load) mAct = mPend;
      if (busWrite && busAddr == 3'd5 && busWdata[0]) mRaw = 0;
      if (load) mRaw = 1;
      if (busWrite && busAddr == 3'd2) mEn = busWdata[0];
      mFlag = (busWrite && busAddr == 3'd0) || (mFlag && !frameStart);
      if (busWrite && busAddr == 3'd0) mPend = busWdata & 32'hFFFF_FFFC;
    end
  end

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mPend;
      3'd1: return mAct;
      3'd2: return {31'd0, mEn};
      3'd3: return {31'd0, mRaw};
      3'd4: return {31'd0, mRaw & mEn};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2 model busRdata", busRdata, modelRead(busAddr));
      check("R3 model activeBase", activeBase, mAct);
      check("R7 model irq", {31'd0, irq}, {31'd0, mRaw & mEn});
    end
  end

  task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d, input bit fs);
    @(negedge clk); #2;
    busWrite = we; busAddr = a; busWdata = d; frameStart = fs;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #2;
    busWrite = 0; frameStart = 0; busAddr = a; busWdata = 0;
    #1 check(tag, busRdata, exp);
  endtask

  task automatic chkIrq(input bit exp, input string tag);
    check(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rstN = 1'b1;
    // R1 reset state
    rd(3'd0, 0, "R1 pending");
    rd(3'd1, 0, "R1 active");
    rd(3'd2, 0, "R1 enable");
    rd(3'd3, 0, "R1 raw");
    chkIrq(0, "R1 irq");
    // R2 pending write, alignment
    step(1, 3'd0, 32'h0000_1003, 0);
    rd(3'd0, 32'h0000_1000, "R2 pending aligned");
    rd(3'd1, 0, "R2 active unchanged");
    step(1, 3'd2, 32'd1, 0);
    // R3 load on frame start
    step(0, 3'd0, 0, 1);
    rd(3'd1, 32'h0000_1000, "R3 active loaded");
    rd(3'd3, 1, "R3 raw set");
    rd(3'd4, 1, "R7 masked");
    chkIrq(1, "R7 irq high");
    // R8 clear
    step(1, 3'd5, 32'd1, 0);
    rd(3'd3, 0, "R8 raw cleared");
    chkIrq(0, "R8 irq low");
    // R4 frame start with nothing pending
    step(0, 3'd0, 0, 1);
    rd(3'd3, 0, "R4 raw stays clear");
    rd(3'd1, 32'h0000_1000, "R4 active unchanged");
    // R5 last write wins, one event
    step(1, 3'd0, 32'h0000_2000, 0);
    step(1, 3'd0, 32'h0000_3000, 0);
    step(1, 3'd0, 32'h0000_4004, 0);
    step(0, 3'd0, 0, 1);
    rd(3'd1, 32'h0000_4004, "R5 last value loaded");
    step(1, 3'd5, 32'd1, 0);
    step(0, 3'd0, 0, 1);
    rd(3'd3, 0, "R5 single event");
    // R6 write coincident with frame start
    step(1, 3'd0, 32'h0000_5000, 0);
    step(1, 3'd0, 32'h0000_6000, 1);
    rd(3'd1, 32'h0000_5000, "R6 old pending loaded");
    rd(3'd0, 32'h0000_6000, "R6 new value pending");
    step(1, 3'd5, 32'd1, 0);
    step(0, 3'd0, 0, 1);
    rd(3'd1, 32'h0000_6000, "R6 loaded next frame");
    step(1, 3'd5, 32'd1, 0);
    // R9 clear and set same cycle
    step(1, 3'd0, 32'h0000_7000, 0);
    step(1, 3'd5, 32'd1, 1);
    rd(3'd3, 1, "R9 set wins");
    // R10 holds
    for (int i = 0; i < 5; i++) step(0, 3'd0, 0, (i == 2));
    rd(3'd3, 1, "R10 raw held");
    chkIrq(1, "R10 irq held");
    // R7 mask
    step(1, 3'd2, 32'd0, 0);
    rd(3'd4, 0, "R7 masked off");
    chkIrq(0, "R7 irq masked");
    rd(3'd3, 1, "R7 raw unaffected");
    // R8 write zero clears nothing
    step(1, 3'd5, 32'd0, 0);
    rd(3'd3, 1, "R8 zero clears nothing");
    step(1, 3'd5, 32'hFFFF_FFFF, 0);
    rd(3'd3, 0, "R8 all ones clears");
    // R11 unused bits and read-only addresses
    step(1, 3'd2, 32'hFFFF_FFFE, 0);
    rd(3'd2, 0, "R11 enable upper bits");
    step(1, 3'd3, 32'hFFFF_FFFF, 0);
    rd(3'd3, 0, "R11 raw write ignored");
    step(1, 3'd1, 32'h0000_ABC0, 0);
    rd(3'd1, 32'h0000_7000, "R11 active write ignored");
    step(1, 3'd4, 32'hFFFF_FFFF, 0);
    rd(3'd4, 0, "R11 masked write ignored");
    rd(3'd5, 0, "R11 clear reads zero");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1'b1;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule